// File: doc/BRIEF.md
# Lock-After-First-Write Watchdog Timer

This block is a countdown watchdog controlled through one memory-mapped word. The first write after reset fixes the whole configuration: the reload count, whether a coarse divider sits in front of the countdown, whether counting runs at all, and how an expiry is signalled. From then on the word is frozen. Every later write, whatever its data, is treated as a keep-alive that restarts the countdown.

The countdown advances on a timer-rate clock enable that the surrounding logic pulses on every second bus clock. If the coarse divider is selected, only one of every 16384 such pulses advances the count. When the count is already at zero and another advance arrives, the block signals a timeout once. Depending on the configured action, that signal is a one-cycle interrupt pulse, a held interrupt level, a held reset request, or nothing at all. A read returns the frozen configuration, the live count and the lock flag, so software and test benches can follow the countdown.

Top module: `wdog_lock_top`

## Requirements
- R1: After reset, rd_data_o reads 0 and both irq_o and rst_req_o are low.
- R2: The first write after reset latches wr_data_i[11:0] as the reload count, bit 12 as the divider select, bit 13 as the run enable and bits 15:14 as the action. From the next cycle the read word shows this configuration in bits 15:0, the live count in bits 27:16 and a lock flag in bit 31, with bits 30:28 zero. The count starts at the reload value. While unlocked, both timeout outputs stay low.
- R3: Once locked, no write changes read bits 15:0 or the lock flag.
- R4: Any write after lock returns the count to the latched reload value on the next cycle and restarts the divider from zero.
- R5: With the run enable set and the divider off, the count drops by one on each cycle where tick_en_i is high. With the run enable clear, the count never moves and no timeout occurs.
- R6: With the divider on, the count advances once per 16384 tick_en_i pulses, so a reload of 0 expires after exactly 16384 pulses.
- R7: A timeout fires on the advance that finds the count at zero. The count then stays at 0, and no further timeout fires until a write restarts it.
- R8: Action codes are: 0 gives no output; 1 raises rst_req_o and holds it; 2 drives irq_o high for exactly one cycle; 3 raises irq_o and holds it.
- R9: Held outputs are cleared only by reset. A restart write after expiry leaves them high.
- R10: If a write lands in the same cycle as an advance, the write wins. The count then equals the reload value and no timeout fires in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Timer-rate enable, high every second bus cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data; only the configuration bits are stored |
| rd_data_o | output | 32 | Lock flag, live count and frozen configuration |
| irq_o | output | 1 | Timeout interrupt, pulse or level |
| rst_req_o | output | 1 | Held timeout reset request |

## Verification
A write is captured on one rising edge, and its effect appears in the read word and count half a cycle later. The bench therefore samples at the falling edge that follows the capture edge. Advances and timeouts are registered on the same edge as the tick that causes them, so irq_o and rst_req_o are compared at the falling edge right after that tick. A cycle-level reference model in the bench is updated on the same edges as the design and compared at every falling edge. Directed waits count whole cycles from the write, so the expected count never depends on which phase tick_en_i happens to be in.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int unsigned CNT_W = 12;

  typedef enum logic [1:0] {
    ACT_NONE      = 2'd0,
    ACT_RESET     = 2'd1,
    ACT_IRQ_PULSE = 2'd2,
    ACT_IRQ_LEVEL = 2'd3
  } act_e;

  // bit positions are software-visible
  typedef struct packed {
    act_e             action;    // 15:14
    logic             run_en;    // 13
    logic             div_en;    // 12
    logic [CNT_W-1:0] reload;    // 11:0
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);
endpackage

// File: rtl/wdog_cfg_lock.sv
`timescale 1ns/1ps
module wdog_cfg_lock
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output cfg_t             cfg_o,
  output logic             locked_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             load_arm_o
);
  cfg_t cfg_q;
  logic locked_q;
  cfg_t wr_cfg;

  assign wr_cfg = cfg_t'(wr_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      locked_q <= 1'b0;
    end else if (wr_en_i && !locked_q) begin
      cfg_q    <= wr_cfg;
      locked_q <= 1'b1;
    end
  end

  // first write loads from the bus, later ones from the frozen copy
  assign load_val_o = locked_q ? cfg_q.reload : wr_cfg.reload;
  assign load_arm_o = locked_q ? cfg_q.run_en : wr_cfg.run_en;
  assign cfg_o      = cfg_q;
  assign locked_o   = locked_q;

  p_cfg_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> (locked_q && $stable(cfg_q)));
endmodule

// File: rtl/wdog_prescale.sv
`timescale 1ns/1ps
module wdog_prescale #(
  parameter int unsigned PRE_W = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic step_o
);
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end

  assign step_o = run_i && (cnt_q == PRE_MAX);

  p_pre_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_countdown.sv
`timescale 1ns/1ps
module wdog_countdown #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         arm_i,
  input  logic         step_i,
  output logic [W-1:0] count_o,
  output logic         fire_o
);
  logic [W-1:0] count_q;
  logic         armed_q;
  logic         zero;

  assign zero   = (count_q == '0);
  assign fire_o = step_i && !load_i && zero && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      count_q <= load_val_i;
      armed_q <= arm_i;
    end else if (step_i) begin
      if (!zero)        count_q <= count_q - 1'b1;
      else if (armed_q) armed_q <= 1'b0;
    end
  end

  assign count_o = count_q;

  p_hold_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero && !load_i) |=> (count_q == '0));
  p_one_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !zero) |=> (count_q == $past(count_q) - 1'b1));
  p_single_fire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !load_i) |=> !fire_o);
endmodule

// File: rtl/wdog_lock_top.sv
`timescale 1ns/1ps
module wdog_lock_top
  import wdog_pkg::*;
#(
  parameter int unsigned PRE_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output logic [31:0]      rd_data_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  localparam int unsigned PAD_W = 32 - 1 - CNT_W - CFG_W;

  cfg_t             cfg;
  logic             locked;
  logic [CNT_W-1:0] load_val;
  logic             load_arm;
  logic             running;
  logic             pre_step;
  logic             step;
  logic [CNT_W-1:0] count;
  logic             fire;
  logic             irq_pulse_q, irq_level_q, rst_level_q;

  wdog_cfg_lock u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .cfg_o      (cfg),
    .locked_o   (locked),
    .load_val_o (load_val),
    .load_arm_o (load_arm)
  );

  assign running = locked && cfg.run_en && tick_en_i;

  wdog_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wr_en_i),
    .run_i  (running && cfg.div_en),
    .step_o (pre_step)
  );

  assign step = running && (cfg.div_en ? pre_step : 1'b1);

  wdog_countdown #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_en_i),
    .load_val_i (load_val),
    .arm_i      (load_arm),
    .step_i     (step),
    .count_o    (count),
    .fire_o     (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_pulse_q <= 1'b0;
      irq_level_q <= 1'b0;
      rst_level_q <= 1'b0;
    end else begin
      irq_pulse_q <= fire && (cfg.action == ACT_IRQ_PULSE);
      if (fire && cfg.action == ACT_IRQ_LEVEL) irq_level_q <= 1'b1;
      if (fire && cfg.action == ACT_RESET)     rst_level_q <= 1'b1;
    end
  end

  assign irq_o     = irq_pulse_q | irq_level_q;
  assign rst_req_o = rst_level_q;
  assign rd_data_o = {locked, {PAD_W{1'b0}}, count, cfg};

  p_quiet_unlocked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked |-> (!irq_o && !rst_req_o));
  p_count_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |-> (count <= cfg.reload));
  p_kick_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && locked) |=> (count == cfg.reload));
  p_pulse_width_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && cfg.action == ACT_IRQ_PULSE) |=> !irq_o);
  p_irq_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && cfg.action == ACT_IRQ_LEVEL) |=> irq_o);
  p_rst_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);
endmodule

// File: tb/tb_wdog_lock_top.sv
`timescale 1ns/1ps
module tb_wdog_lock_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o, rst_req_o;

  int tests = 0;
  int fails = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  wdog_lock_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_en_i(tick_en_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always #2.5 clk_i = ~clk_i;
  always @(negedge clk_i) tick_en_i <= ~tick_en_i;

  // reference model of the requirements
  logic [15:0] m_cfg;
  logic        m_lock, m_arm, m_pulse, m_irql, m_rstl;
  logic [11:0] m_cnt;
  logic [13:0] m_pre;

  always @(posedge clk_i or negedge rst_ni) begin : model
    bit adv;
    if (!rst_ni) begin
      m_cfg <= '0; m_lock <= 0; m_arm <= 0; m_pulse <= 0; m_irql <= 0; m_rstl <= 0;
      m_cnt <= '0; m_pre <= '0;
    end else begin
      m_pulse <= 1'b0;
      if (wr_en_i) begin
        m_pre <= '0;
        if (!m_lock) begin
          m_lock <= 1'b1; m_cfg <= wr_data_i; m_cnt <= wr_data_i[11:0]; m_arm <= wr_data_i[13];
        end else begin
          m_cnt <= m_cfg[11:0]; m_arm <= m_cfg[13];
        end
      end else if (m_lock && m_cfg[13] && tick_en_i) begin
        adv = 1'b1;
        if (m_cfg[12]) begin
          adv = (m_pre == 14'h3fff);
          m_pre <= m_pre + 1'b1;
        end
        if (adv) begin
          if (m_cnt != 0) m_cnt <= m_cnt - 1'b1;
          else if (m_arm) begin
            m_arm <= 1'b0;
            case (m_cfg[15:14])
              2'd1: m_rstl <= 1'b1;
              2'd2: m_pulse <= 1'b1;
              2'd3: m_irql <= 1'b1;
              default: ;
            endcase
          end
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (cmp_on && rst_ni) begin
    chk("R2 readback", rd_data_o, {m_lock, 3'b000, m_cnt, m_cfg});
    chk("R8 irq_o", {31'd0, irq_o}, {31'd0, m_pulse | m_irql});
    chk("R8 rst_req_o", {31'd0, rst_req_o}, {31'd0, m_rstl});
  end

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0; wr_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin : wdog
    for (int i = 0; i < 190000; i++) begin
      @(posedge clk_i);
      if (done) disable wdog;
    end
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int pulses;
    void'($urandom(32'd1234));
    do_reset();
    @(negedge clk_i);
    chk("R1 rd_data", rd_data_o, 32'h0);
    chk("R1 irq", {31'd0, irq_o}, 32'h0);
    chk("R1 rst_req", {31'd0, rst_req_o}, 32'h0);
    cmp_on = 1'b1;

    // R2: pulse irq, enabled, reload 10
    wr(16'hA00A);
    chk("R2 config", {16'd0, rd_data_o[15:0]}, 32'h0000A00A);
    chk("R2 lock", {31'd0, rd_data_o[31]}, 32'h1);
    chk("R2 count", {20'd0, rd_data_o[27:16]}, 32'd10);
    wait_cyc(5);
    wr(16'hFFFF);
    chk("R3 config frozen", {16'd0, rd_data_o[15:0]}, 32'h0000A00A);
    chk("R4 kick reload", {20'd0, rd_data_o[27:16]}, 32'd10);
    wr(16'h0000);
    chk("R10 kick vs tick", {20'd0, rd_data_o[27:16]}, 32'd10);
    wr(16'h1234);
    chk("R10 kick vs tick", {20'd0, rd_data_o[27:16]}, 32'd10);
    pulses = 0;
    for (int i = 0; i < 120; i++) begin @(negedge clk_i); if (irq_o) pulses++; end
    chk("R7 single pulse", pulses, 1);
    chk("R7 count held", {20'd0, rd_data_o[27:16]}, 32'd0);

    // R5 rate
    do_reset(); wr(16'h2014); wait_cyc(20);
    chk("R5 count rate", {20'd0, rd_data_o[27:16]}, 32'd10);

    // R9 held irq
    do_reset(); wr(16'hE003); wait_cyc(30);
    chk("R9 irq level", {31'd0, irq_o}, 32'h1);
    wr(16'h0000);
    chk("R9 kick keeps irq", {31'd0, irq_o}, 32'h1);
    wait_cyc(30);
    chk("R9 irq still", {31'd0, irq_o}, 32'h1);
    do_reset(); @(negedge clk_i);
    chk("R9 reset clears", {31'd0, irq_o}, 32'h0);

    // R8 reset request
    do_reset(); wr(16'h6002); wait_cyc(20);
    chk("R8 rst_req", {31'd0, rst_req_o}, 32'h1);
    chk("R8 no irq", {31'd0, irq_o}, 32'h0);

    // R5 disabled
    do_reset(); wr(16'h8005); wait_cyc(50);
    chk("R5 disabled count", {20'd0, rd_data_o[27:16]}, 32'd5);
    wr(16'hA005); wait_cyc(50);
    chk("R3 enable not settable", {16'd0, rd_data_o[15:0]}, 32'h00008005);
    chk("R5 still held", {20'd0, rd_data_o[27:16]}, 32'd5);
    chk("R5 no timeout", {30'd0, irq_o, rst_req_o}, 32'h0);

    // R8 action none
    do_reset(); wr(16'h2001); wait_cyc(20);
    chk("R8 none", {30'd0, irq_o, rst_req_o}, 32'h0);
    chk("R8 none count", {20'd0, rd_data_o[27:16]}, 32'd0);

    // R6 divider
    do_reset(); wr(16'h7000); wait_cyc(32700);
    chk("R6 not yet", {31'd0, rst_req_o}, 32'h0);
    wait_cyc(100);
    chk("R6 expired", {31'd0, rst_req_o}, 32'h1);

    // random configurations with random kicks
    for (int r = 0; r < 8; r++) begin
      logic [15:0] d;
      do_reset();
      d = 16'($urandom());
      d[12] = 1'b0;
      d[11:0] = 12'($urandom_range(0, 30));
      if ($urandom_range(0, 4) != 0) d[13] = 1'b1;
      wr(d);
      for (int c = 0; c < 2000; c++) begin
        if ($urandom_range(0, 39) == 0) wr(16'($urandom()));
        else @(negedge clk_i);
      end
    end

    cmp_on = 1'b0;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule